// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates among a set of device interrupt request lines plus one non-maskable line. It compares the best pending request with the priority of the handler that is running now. When the CPU side is ready, it acknowledges exactly one device. That device then places its vector number on a shared return bus. The controller captures the vector and offers it to the CPU as an index into the handler table. It offers it through a valid/ready pair.

The controller keeps a stack of in-service priority levels. A dispatch pushes the dispatched level. An end-of-interrupt pulse pops it. Nested handlers therefore mask every request at or below their own level, and the previous level returns once they finish. If a device that was acknowledged does not return a vector within a fixed number of cycles, the controller raises a one-cycle bus error and returns to idle. It dispatches nothing in that case.

CPU-side rules: `int_valid` rises with `int_vec` and holds both stable until a cycle with `cpu_ready` high, and the transfer completes in that cycle. While `cpu_ready` is low in the idle state, no device is acknowledged, and requests stay pending.

Top module: `pvic_top`

## Requirements
- R1: Among pending maskable requests, line 0 has the highest priority and higher indices rank lower. Line i carries level N-i, and the idle level is 0.
- R2: A maskable request is acknowledged only when its level is strictly greater than the level on top of the in-service stack. With nothing in service, any request qualifies. A request at an equal or lower level gets no acknowledge while the current level stands.
- R3: The non-maskable line has level N+1 and outranks every maskable line. It is masked only while a non-maskable service is itself in service.
- R4: An acknowledge is issued only when `cpu_ready` is high in the arbitration cycle. It appears one cycle later, on exactly one of `irq_ack`/`nmi_ack`. It holds until a vector arrives or the timeout expires.
- R5: A vector seen with `vec_valid` during acknowledge is captured and shown on `int_vec` with `int_valid` in the next cycle. Both are held stable until `cpu_ready` is high. That transfer pushes the dispatched level.
- R6: After TIMEOUT acknowledge cycles with no `vec_valid`, `bus_err` is high for exactly one cycle. Acknowledge drops, nothing is dispatched, and the in-service level is unchanged.
- R7: An `eoi` pulse pops one level, which restores the level that was in force before the last dispatch. An `eoi` with an empty stack has no effect.
- R8: A request that drops before it is acknowledged is withdrawn. Arbitration uses the request lines as they stand in the cycle the acknowledge is decided.
- R9: Synchronous active-high `rst` empties the in-service stack and clears acknowledge, `int_valid` and `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N | Maskable request lines, line 0 highest priority |
| nmi_req | input | 1 | Non-maskable request |
| irq_ack | output | N | One-hot acknowledge to maskable devices |
| nmi_ack | output | 1 | Acknowledge to the non-maskable device |
| vec_valid | input | 1 | Device vector return strobe |
| vec_in | input | VEC_W | Vector number returned by the acknowledged device |
| int_valid | output | 1 | Vector offered to the CPU |
| int_vec | output | VEC_W | Handler table index |
| cpu_ready | input | 1 | CPU can take an interrupt now |
| eoi | input | 1 | End of interrupt, pops one in-service level |
| bus_err | output | 1 | One-cycle pulse on vector fetch timeout |

## Verification
An acknowledge is due one cycle after the cycle in which requests and `cpu_ready` are driven. `int_valid` and the vector are due one cycle after `vec_valid`. `int_valid` falls one cycle after `cpu_ready` meets it. `bus_err` shows in the cycle after the TIMEOUT-th acknowledge cycle. The bench drives inputs and samples outputs on the falling edge, and it counts rising edges from each stimulus to these points. Masking is observed by the presence or absence of an acknowledge one cycle after a single-line request. This shows the stack's level at the ports after each push, pop, timeout and reset.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_DISP = 2'd2
  } hs_state_t;
endpackage

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
  parameter int N     = 8,
  parameter int LVL_W = 4
) (
  input  logic [N-1:0]     req,
  input  logic             nmi,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic             win_valid,
  output logic [N:0]       win_sel,
  output logic [LVL_W-1:0] win_lvl
);
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(N + 1);

  logic [LVL_W-1:0] line_lvl [N];
  logic [N-1:0]     best_sel;
  logic [LVL_W-1:0] best_lvl;
  logic             any_req;

  for (genvar g = 0; g < N; g++) begin : g_lvl
    assign line_lvl[g] = LVL_W'(N - g);
  end

  // lowest index wins: scan downwards, last hit stays
  always_comb begin
    best_sel = '0;
    best_lvl = '0;
    any_req  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        best_sel    = '0;
        best_sel[i] = 1'b1;
        best_lvl    = line_lvl[i];
        any_req     = 1'b1;
      end
    end
  end

  always_comb begin
    if (nmi && (cur_lvl != NMI_LVL)) begin
      win_sel    = '0;
      win_sel[N] = 1'b1;
      win_lvl    = NMI_LVL;
      win_valid  = 1'b1;
    end else begin
      win_sel   = {1'b0, best_sel};
      win_lvl   = best_lvl;
      win_valid = any_req && (best_lvl > cur_lvl);
    end
  end
endmodule

// File: rtl/pvic_lvl_stack.sv
module pvic_lvl_stack #(
  parameter int DEPTH = 9,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] top_lvl
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LVL_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             pop_eff;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] top_idx;

  assign pop_eff = pop && (cnt != '0);
  assign wr_idx  = IDX_W'(cnt);
  assign top_idx = IDX_W'(cnt - 1'b1);
  assign top_lvl = (cnt == '0) ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      unique case ({push, pop_eff})
        2'b10: if (cnt < CNT_W'(DEPTH)) begin
          mem[wr_idx] <= push_lvl;
          cnt         <= cnt + 1'b1;
        end
        2'b01: cnt <= cnt - 1'b1;
        2'b11: mem[top_idx] <= push_lvl;
        default: ;
      endcase
    end
  end

  AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && !pop_eff) |-> (cnt < CNT_W'(DEPTH)));  // R7
  AST_POP_LOWERS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (pop_eff && !push && cnt > CNT_W'(1)) |=> (top_lvl < $past(top_lvl)));  // R7
endmodule

// File: rtl/pvic_handshake.sv
module pvic_handshake
  import pvic_pkg::*;
#(
  parameter int N       = 8,
  parameter int VEC_W   = 8,
  parameter int LVL_W   = 4,
  parameter int TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_valid,
  input  logic [N:0]       win_sel,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic             cpu_ready,
  input  logic             vec_valid,
  input  logic [VEC_W-1:0] vec_in,
  output logic [N:0]       ack_sel,
  output logic             int_valid,
  output logic [VEC_W-1:0] int_vec,
  output logic             push,
  output logic [LVL_W-1:0] push_lvl,
  output logic             bus_err
);
  localparam int TMR_W = $clog2(TIMEOUT + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  hs_state_t        st;
  logic [N:0]       sel_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sel_q   <= '0;
      lvl_q   <= '0;
      vec_q   <= '0;
      tmr     <= '0;
      bus_err <= 1'b0;
    end else begin
      bus_err <= 1'b0;
      unique case (st)
        ST_IDLE: if (win_valid && cpu_ready) begin
          st    <= ST_ACK;
          sel_q <= win_sel;
          lvl_q <= win_lvl;
          tmr   <= '0;
        end
        ST_ACK: if (vec_valid) begin
          vec_q <= vec_in;
          st    <= ST_DISP;
        end else if (tmr == TMR_LAST) begin
          bus_err <= 1'b1;
          sel_q   <= '0;
          st      <= ST_IDLE;
        end else begin
          tmr <= tmr + 1'b1;
        end
        ST_DISP: if (cpu_ready) begin
          sel_q <= '0;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ack_sel   = (st == ST_ACK) ? sel_q : '0;
  assign int_valid = (st == ST_DISP);
  assign int_vec   = vec_q;
  assign push      = int_valid && cpu_ready;
  assign push_lvl  = lvl_q;

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_sel));  // R4
  AST_ACK_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(|ack_sel) |-> $past(cpu_ready));  // R4
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (rst)
    (int_valid && !cpu_ready) |=> (int_valid && $stable(int_vec)));  // R5
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> !bus_err);  // R6
  AST_ERR_FROM_ACK: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> ($past(|ack_sel) && !int_valid && ack_sel == '0));  // R6
endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
  parameter int N       = 8,
  parameter int VEC_W   = 8,
  parameter int TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     irq_req,
  input  logic             nmi_req,
  output logic [N-1:0]     irq_ack,
  output logic             nmi_ack,
  input  logic             vec_valid,
  input  logic [VEC_W-1:0] vec_in,
  output logic             int_valid,
  output logic [VEC_W-1:0] int_vec,
  input  logic             cpu_ready,
  input  logic             eoi,
  output logic             bus_err
);
  localparam int LVL_W = $clog2(N + 2);
  localparam int DEPTH = N + 1;
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(N + 1);

  logic             win_valid;
  logic [N:0]       win_sel;
  logic [LVL_W-1:0] win_lvl;
  logic [LVL_W-1:0] cur_lvl;
  logic [N:0]       ack_sel;
  logic             push;
  logic [LVL_W-1:0] push_lvl;

  pvic_arbiter #(.N(N), .LVL_W(LVL_W)) u_arb (
    .req(irq_req), .nmi(nmi_req), .cur_lvl(cur_lvl),
    .win_valid(win_valid), .win_sel(win_sel), .win_lvl(win_lvl)
  );

  pvic_handshake #(.N(N), .VEC_W(VEC_W), .LVL_W(LVL_W), .TIMEOUT(TIMEOUT)) u_hs (
    .clk(clk), .rst(rst),
    .win_valid(win_valid), .win_sel(win_sel), .win_lvl(win_lvl),
    .cpu_ready(cpu_ready), .vec_valid(vec_valid), .vec_in(vec_in),
    .ack_sel(ack_sel), .int_valid(int_valid), .int_vec(int_vec),
    .push(push), .push_lvl(push_lvl), .bus_err(bus_err)
  );

  pvic_lvl_stack #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_stk (
    .clk(clk), .rst(rst),
    .push(push), .push_lvl(push_lvl), .pop(eoi), .top_lvl(cur_lvl)
  );

  assign irq_ack = ack_sel[N-1:0];
  assign nmi_ack = ack_sel[N];

  AST_GRANT_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $rose(|ack_sel) |-> $past(win_lvl > cur_lvl));  // R2
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (rst)
    (nmi_req && cur_lvl != NMI_LVL) |-> (win_valid && win_sel[N]));  // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (ack_sel == '0 && !int_valid && !bus_err && cur_lvl == '0));  // R9
endmodule

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
  localparam int N       = 4;
  localparam int VEC_W   = 4;
  localparam int TIMEOUT = 6;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     irq_req = '0;
  logic             nmi_req = 1'b0;
  logic [N-1:0]     irq_ack;
  logic             nmi_ack;
  logic             vec_valid = 1'b0;
  logic [VEC_W-1:0] vec_in = '0;
  logic             int_valid;
  logic [VEC_W-1:0] int_vec;
  logic             cpu_ready = 1'b0;
  logic             eoi = 1'b0;
  logic             bus_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pvic_top #(.N(N), .VEC_W(VEC_W), .TIMEOUT(TIMEOUT)) dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .nmi_req(nmi_req),
    .irq_ack(irq_ack), .nmi_ack(nmi_ack), .vec_valid(vec_valid), .vec_in(vec_in),
    .int_valid(int_valid), .int_vec(int_vec), .cpu_ready(cpu_ready),
    .eoi(eoi), .bus_err(bus_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ackv();
    return int'({nmi_ack, irq_ack});
  endfunction

  // called one falling edge after the request was driven with cpu_ready high
  task automatic finish_service(input string tag, input int idx, input int v);
    chk({tag, " ack"}, ackv(), 1 << idx);
    vec_valid = 1'b1;
    vec_in    = VEC_W'(v);
    tick();
    vec_valid = 1'b0;
    irq_req   = '0;
    nmi_req   = 1'b0;
    chk({tag, " R5 int_valid"}, int'(int_valid), 1);
    chk({tag, " R5 int_vec"}, int'(int_vec), v);
    tick();
    chk({tag, " R5 taken"}, int'(int_valid), 0);
  endtask

  task automatic eoi_pulse();
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
  endtask

  task automatic try_line(input string tag, input int j, input bit expect_ack);
    irq_req   = N'(1 << j);
    cpu_ready = 1'b1;
    tick();
    if (expect_ack) begin
      finish_service(tag, j, 8 + j);
      eoi_pulse();
    end else begin
      chk({tag, " masked"}, ackv(), 0);
      irq_req = '0;
      tick();
    end
  endtask

  task automatic serve_hold(input string tag, input int j);
    irq_req   = N'(1 << j);
    cpu_ready = 1'b1;
    tick();
    finish_service(tag, j, 8 + j);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R9: quiet outputs in reset
    chk("R9 ack in reset", ackv(), 0);
    chk("R9 int_valid in reset", int'(int_valid), 0);
    chk("R9 bus_err in reset", int'(bus_err), 0);
    rst = 1'b0;
    tick();

    // R1: sweep every request pattern with nothing in service
    for (int p = 0; p < (1 << N); p++) begin
      int lo;
      lo = -1;
      for (int b = N - 1; b >= 0; b--) if (p[b]) lo = b;
      irq_req   = N'(p);
      cpu_ready = 1'b1;
      tick();
      if (lo < 0) begin
        chk("R1 no request", ackv(), 0);
        irq_req = '0;
        tick();
      end else begin
        finish_service("R1 lowest wins", lo, 8 + lo);
        eoi_pulse();
      end
    end

    // R2: line k in service, every other line tried alone
    for (int k = 0; k < N; k++) begin
      serve_hold("R2 base", k);
      for (int j = 0; j < N; j++) begin
        try_line("R2 vs level", j, j < k);
      end
      eoi_pulse();
    end

    // R3: NMI preempts line 0, then is masked by itself
    serve_hold("R3 base", 0);
    nmi_req   = 1'b1;
    irq_req   = N'(1);
    cpu_ready = 1'b1;
    tick();
    finish_service("R3 nmi outranks", N, 15);
    nmi_req = 1'b1;
    tick();
    chk("R3 nmi masked by nmi in service", ackv(), 0);
    nmi_req = 1'b0;
    tick();
    eoi_pulse();
    try_line("R3 back to line0 level", 0, 1'b0);
    try_line("R3 back to line0 level", 3, 1'b0);
    eoi_pulse();
    try_line("R7 idle level", 3, 1'b1);

    // R4/R8: no ack without ready; withdrawn request ignored
    cpu_ready = 1'b0;
    irq_req   = N'(1 << 3);
    tick(); tick(); tick();
    chk("R4 no ack while not ready", ackv(), 0);
    irq_req   = N'(1 << 1);
    cpu_ready = 1'b1;
    tick();
    finish_service("R8 withdrawn line3", 1, 9);
    eoi_pulse();

    // R5: offer held under back-pressure
    irq_req   = N'(1 << 2);
    cpu_ready = 1'b1;
    tick();
    chk("R4 ack line2", ackv(), 1 << 2);
    vec_valid = 1'b1;
    vec_in    = 4'd11;
    cpu_ready = 1'b0;
    tick();
    vec_valid = 1'b0;
    irq_req   = '0;
    for (int c = 0; c < 3; c++) begin
      chk("R5 held valid", int'(int_valid), 1);
      chk("R5 held vector", int'(int_vec), 11);
      tick();
    end
    cpu_ready = 1'b1;
    tick();
    chk("R5 taken after ready", int'(int_valid), 0);
    try_line("R5 level pushed", 3, 1'b0);
    try_line("R5 level pushed", 2, 1'b0);
    eoi_pulse();

    // R6: timeout while line 1 in service
    serve_hold("R6 base", 1);
    irq_req   = N'(1);
    cpu_ready = 1'b1;
    tick();
    chk("R6 ack line0", ackv(), 1);
    irq_req = '0;
    for (int c = 1; c < TIMEOUT; c++) tick();
    chk("R6 ack still held", ackv(), 1);
    chk("R6 no error yet", int'(bus_err), 0);
    tick();
    chk("R6 bus_err", int'(bus_err), 1);
    chk("R6 ack dropped", ackv(), 0);
    chk("R6 no dispatch", int'(int_valid), 0);
    tick();
    chk("R6 bus_err one cycle", int'(bus_err), 0);
    try_line("R6 level kept", 2, 1'b0);
    try_line("R6 level kept", 0, 1'b1);
    eoi_pulse();
    try_line("R7 popped to idle", 3, 1'b1);

    // R7: nesting and pop order, empty pop harmless
    serve_hold("R7 outer", 2);
    serve_hold("R7 inner", 1);
    try_line("R7 inner masks", 1, 1'b0);
    eoi_pulse();
    try_line("R7 outer restored", 2, 1'b0);
    try_line("R7 outer restored", 1, 1'b1);
    eoi_pulse();
    eoi_pulse();
    try_line("R7 empty pop", 3, 1'b1);

    // R9: reset empties the stack
    serve_hold("R9 base", 3);
    try_line("R9 before reset", 3, 1'b0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    try_line("R9 stack cleared", 3, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule